// File: doc/BRIEF.md
# Lockable Two-Stage Watchdog Timer

This block is a bus-attached watchdog peripheral with a simple 32-bit register port. The port has an address, write data, a write strobe, a read strobe and read data. A down-counter runs once per clock while the block is enabled. When the counter runs out for the first time, the block raises an interrupt and reloads from the load register. If software has not cleared that interrupt when the counter runs out again, the block drives a system reset pulse, provided the reset output is enabled.

Stray writes are kept out by a write-protect lock. The block comes out of reset locked. While it is locked, every write except a write to the lock register is dropped. Writing the 32-bit key 0x1ACCE551 to the lock register opens the block. Writing any other value closes it again. Software services the watchdog by writing any value to the interrupt clear register, which also restarts the countdown.

The expiry sequencing is a four-state machine:

| State | Meaning |
| --- | --- |
| ST_IDLE | Stopped, no interrupt pending. |
| ST_IDLE_PEND | Stopped, interrupt pending. |
| ST_FIRST | Counting toward the first expiry. |
| ST_SECOND | Counting toward the second expiry, interrupt pending. |

Its transitions are:

| Transition | Effect |
| --- | --- |
| start | A control write with the enable bit set. It goes to ST_FIRST, or to ST_SECOND if an interrupt is pending, and reloads the counter. |
| stop | A control write with the enable bit clear. It goes to ST_IDLE or ST_IDLE_PEND and keeps the pending flag. |
| service | An interrupt clear write. ST_SECOND goes to ST_FIRST, ST_IDLE_PEND goes to ST_IDLE, and the counter reloads. |
| first expiry | ST_FIRST goes to ST_SECOND. |
| bite | An expiry in ST_SECOND. The state stays ST_SECOND, and a reset pulse is fired if reset is enabled. |

Top module: `wdt_top`

## Requirements
- R1: After reset the block reads as follows, and both outputs are low:

  | Register | Value |
  | --- | --- |
  | control | 0 |
  | load | 0xFFFFFFFF |
  | raw status | 0 |
  | masked status | 0 |
  | lock | 1 |

- R2: The lock register is at byte offset 0xC00 and takes writes at all times. Writing 0x1ACCE551 makes it read 0 (open). Writing any other value makes it read 1 (locked).
- R3: While the lock reads 1, writes to every other register are ignored. The load (0x000) and control (0x008) registers keep their values.
- R4: Control (0x008) bit 0 enables counting and the interrupt, and bit 1 enables the reset output. Bits 31:2 read as zero.
- R5: A control write with bit 0 set loads the counter from the load register. The counter then decrements by one per clock. The counter reads at 0x004, and writes to 0x004 are ignored.
- R6: With load value L, the raw interrupt status (0x010, bit 0) sets L+1 clocks after the counter was loaded. The counter reloads at that point and keeps counting.
- R7: An expiry while the raw interrupt is set, with control bit 1 set, drives the reset output high for exactly RST_CYCLES clocks, starting L+1 clocks after the first expiry. With control bit 1 clear, no pulse is produced and the interrupt stays set.
- R8: A write of any value to the interrupt clear register (0x00C) clears the raw interrupt and reloads the counter from the load register.
- R9: Masked status (0x014, bit 0) equals the raw status ANDed with the enable bit, and the interrupt output equals the masked status. Clearing the enable bit while an interrupt is pending leaves the raw status at 1.
- R10: While the enable bit is clear, the counter holds its value.

## Ports
| Port | Direction | Width | Description |
| --- | --- | --- | --- |
| clk | input | 1 | Clock for the bus and the counter |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wdata | input | DATA_W | Write data |
| bus_wr | input | 1 | Write strobe, one access per clock |
| bus_rd | input | 1 | Read strobe; read data is zero when low |
| bus_rdata | output | DATA_W | Combinational read data |
| irq_o | output | 1 | Interrupt level, equal to the masked status |
| sys_rst_o | output | 1 | Registered system reset pulse |

## Verification
The bench times both expiries against the load value, so a counter that is off by one cycle shows up as a wrong cycle count for the interrupt or for the reset edge. It measures the width of the reset pulse and checks that no pulse appears when reset is disabled. A design that bit on the first expiry, or that ignored the reset-enable bit, fails those checks.

The bench writes while the block is locked, writes a wrong key, and writes to the read-only counter. A leaky lock or a writable counter changes a value that is read back afterwards. It also disables the block with an interrupt pending, which catches a design that drops the raw flag or leaves the interrupt output high. Finally it confirms that the counter freezes while the block is stopped.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
    localparam int ADDR_W = 12;
    localparam logic [ADDR_W-1:0] OFS_LOAD  = 12'h000;
    localparam logic [ADDR_W-1:0] OFS_COUNT = 12'h004;
    localparam logic [ADDR_W-1:0] OFS_CTRL  = 12'h008;
    localparam logic [ADDR_W-1:0] OFS_CLR   = 12'h00C;
    localparam logic [ADDR_W-1:0] OFS_RAW   = 12'h010;
    localparam logic [ADDR_W-1:0] OFS_MSK   = 12'h014;
    localparam logic [ADDR_W-1:0] OFS_LOCK  = 12'hC00;
    localparam logic [31:0]       UNLOCK_KEY = 32'h1ACCE551;

    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_IDLE_PEND = 2'd1,
        ST_FIRST     = 2'd2,
        ST_SECOND    = 2'd3
    } wdt_state_e;
endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
    import wdt_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              wr,
    output logic [DATA_W-1:0] load_q,
    output logic              ctrl_en,
    output logic              ctrl_rsten,
    output logic              locked,
    output logic              start_ev,
    output logic              stop_ev,
    output logic              clr_ev
);
    logic wr_open;
    logic ctrl_hit;

    assign wr_open  = wr && !locked;
    assign ctrl_hit = wr_open && (addr == OFS_CTRL);
    assign start_ev = ctrl_hit && wdata[0];
    assign stop_ev  = ctrl_hit && !wdata[0];
    assign clr_ev   = wr_open && (addr == OFS_CLR);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            load_q     <= '1;
            ctrl_en    <= 1'b0;
            ctrl_rsten <= 1'b0;
            locked     <= 1'b1;
        end else begin
            if (wr && addr == OFS_LOCK)
                locked <= (wdata[31:0] != UNLOCK_KEY);
            if (wr_open && addr == OFS_LOAD)
                load_q <= wdata;
            if (ctrl_hit) begin
                ctrl_en    <= wdata[0];
                ctrl_rsten <= wdata[1];
            end
        end
    end
endmodule

// File: rtl/wdt_core.sv
module wdt_core
    import wdt_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] load_val,
    input  logic              start_ev,
    input  logic              stop_ev,
    input  logic              clr_ev,
    input  logic              rsten,
    output logic [DATA_W-1:0] cnt_q,
    output logic              raw_irq,
    output logic              bite
);
    wdt_state_e state_q, state_d;
    logic running;
    logic expire;

    assign running = (state_q == ST_FIRST) || (state_q == ST_SECOND);
    assign expire  = running && (cnt_q == '0) && !start_ev && !stop_ev && !clr_ev;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_ev) state_d = ST_FIRST;
            end
            ST_IDLE_PEND: begin
                if (start_ev)    state_d = ST_SECOND;
                else if (clr_ev) state_d = ST_IDLE;
            end
            ST_FIRST: begin
                if (stop_ev)     state_d = ST_IDLE;
                else if (expire) state_d = ST_SECOND;
            end
            ST_SECOND: begin
                if (stop_ev)     state_d = ST_IDLE_PEND;
                else if (clr_ev) state_d = ST_FIRST;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Countdown register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '1;
        else if (start_ev || clr_ev)
            cnt_q <= load_val;
        else if (running && !stop_ev)
            cnt_q <= (cnt_q == '0) ? load_val : cnt_q - 1'b1;
    end

    // Outputs
    always_comb begin
        raw_irq = (state_q == ST_IDLE_PEND) || (state_q == ST_SECOND);
        bite    = expire && (state_q == ST_SECOND) && rsten;
    end
endmodule

// File: rtl/wdt_rstpulse.sv
module wdt_rstpulse #(
    parameter int RST_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    output logic pulse_q
);
    localparam int PW = $clog2(RST_CYCLES + 1);
    localparam logic [PW-1:0] PLEN = PW'(RST_CYCLES);

    logic [PW-1:0] left_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            left_q  <= '0;
            pulse_q <= 1'b0;
        end else if (fire) begin
            left_q  <= PLEN;
            pulse_q <= 1'b1;
        end else begin
            pulse_q <= (left_q > PW'(1));
            if (left_q != '0) left_q <= left_q - 1'b1;
        end
    end
endmodule

// File: rtl/wdt_top.sv
module wdt_top
    import wdt_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int RST_CYCLES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_wr,
    input  logic              bus_rd,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_o,
    output logic              sys_rst_o
);
    logic [DATA_W-1:0] load_q;
    logic [DATA_W-1:0] cnt_q;
    logic ctrl_en, ctrl_rsten, locked;
    logic start_ev, stop_ev, clr_ev;
    logic raw_irq, bite;

    wdt_regs #(.DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .addr(bus_addr), .wdata(bus_wdata), .wr(bus_wr),
        .load_q(load_q), .ctrl_en(ctrl_en), .ctrl_rsten(ctrl_rsten), .locked(locked),
        .start_ev(start_ev), .stop_ev(stop_ev), .clr_ev(clr_ev)
    );

    wdt_core #(.DATA_W(DATA_W)) u_core (
        .clk(clk), .rst_n(rst_n), .load_val(load_q),
        .start_ev(start_ev), .stop_ev(stop_ev), .clr_ev(clr_ev), .rsten(ctrl_rsten),
        .cnt_q(cnt_q), .raw_irq(raw_irq), .bite(bite)
    );

    wdt_rstpulse #(.RST_CYCLES(RST_CYCLES)) u_pulse (
        .clk(clk), .rst_n(rst_n), .fire(bite), .pulse_q(sys_rst_o)
    );

    assign irq_o = raw_irq && ctrl_en;

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            unique case (bus_addr)
                OFS_LOAD:  bus_rdata = load_q;
                OFS_COUNT: bus_rdata = cnt_q;
                OFS_CTRL:  bus_rdata = DATA_W'({ctrl_rsten, ctrl_en});
                OFS_RAW:   bus_rdata = DATA_W'(raw_irq);
                OFS_MSK:   bus_rdata = DATA_W'(irq_o);
                OFS_LOCK:  bus_rdata = DATA_W'(locked);
                default:   bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/wdt_chk.sv
module wdt_chk
    import wdt_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              bus_wr,
    input logic              sys_rst_o,
    input logic [DATA_W-1:0] load_q,
    input logic [DATA_W-1:0] cnt_q,
    input logic              ctrl_en,
    input logic              ctrl_rsten,
    input logic              locked,
    input logic              raw_irq
);
    p_unlock_r2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr && bus_addr == OFS_LOCK |=> locked == ($past(bus_wdata[31:0]) != UNLOCK_KEY));

    p_lock_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        locked && bus_wr && bus_addr != OFS_LOCK |=> $stable(load_q) && $stable(ctrl_en));

    p_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr && !locked && bus_addr == OFS_CTRL && bus_wdata[0] |=> cnt_q == $past(load_q));

    p_first_expiry_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_en && cnt_q == '0 && !raw_irq && !bus_wr |=> raw_irq);

    p_bite_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sys_rst_o) |-> $past(raw_irq) && $past(ctrl_rsten));

    p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr && !locked && bus_addr == OFS_CLR |=> !raw_irq && cnt_q == $past(load_q));

    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_en && !bus_wr |=> $stable(cnt_q));
endmodule

bind wdt_top wdt_chk #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_wr(bus_wr),
    .sys_rst_o(sys_rst_o), .load_q(load_q), .cnt_q(cnt_q), .ctrl_en(ctrl_en),
    .ctrl_rsten(ctrl_rsten), .locked(locked), .raw_irq(raw_irq)
);

// File: tb/wdt_top_bench.sv
module wdt_top_bench;
    localparam int CLK_PERIOD = 10;
    localparam int RSTC = 4;
    localparam logic [31:0] LV = 32'd9;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic bus_wr = 1'b0;
    logic bus_rd = 1'b0;
    logic [31:0] bus_rdata;
    logic irq_o, sys_rst_o;

    int n_cmp = 0;
    int n_bad = 0;
    logic [31:0] exp_q[$];
    string tag_q[$];
    event rd_ev;

    always #(CLK_PERIOD/2) clk = ~clk;

    wdt_top #(.DATA_W(32), .RST_CYCLES(RSTC)) u_wdt_top (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .irq_o(irq_o), .sys_rst_o(sys_rst_o)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] expv, input string tag);
        n_cmp++;
        if (act !== expv) begin
            n_bad++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", tag, act, expv);
        end
    endtask

    // Scoreboard monitor: pops an expectation at each read sample point
    always begin
        @(rd_ev);
        chk(bus_rdata, exp_q.pop_front(), tag_q.pop_front());
    end

    // All tasks start and end at a falling edge
    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, input logic [31:0] expv, input string tag);
        exp_q.push_back(expv);
        tag_q.push_back(tag);
        bus_addr = a; bus_rd = 1'b1;
        #2 ->rd_ev;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic wait_irq(output int k);
        k = 0;
        do begin @(posedge clk); #1; k++; end while (!irq_o && k < 1000);
        @(negedge clk);
    endtask

    task automatic wait_rst(output int k);
        k = 0;
        do begin @(posedge clk); #1; k++; end while (!sys_rst_o && k < 1000);
        @(negedge clk);
    endtask

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        int k;
        int seen;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk({31'd0, irq_o}, 32'd0, "R1 irq_o");
        chk({31'd0, sys_rst_o}, 32'd0, "R1 sys_rst_o");
        rd(12'h008, 32'd0, "R1 control");
        rd(12'h000, 32'hFFFFFFFF, "R1 load");
        rd(12'hC00, 32'd1, "R1 lock");
        rd(12'h010, 32'd0, "R1 raw");
        rd(12'h014, 32'd0, "R1 masked");

        // R3 locked writes ignored
        wr(12'h000, LV);
        rd(12'h000, 32'hFFFFFFFF, "R3 load while locked");
        wr(12'h008, 32'd3);
        rd(12'h008, 32'd0, "R3 control while locked");

        // R2 wrong key then right key
        wr(12'hC00, 32'h12345678);
        rd(12'hC00, 32'd1, "R2 wrong key");
        wr(12'hC00, 32'h1ACCE551);
        rd(12'hC00, 32'd0, "R2 key opens");

        // R4 reserved bits
        wr(12'h000, LV);
        rd(12'h000, LV, "R4 load write");
        wr(12'h008, 32'hFFFFFFFE);
        rd(12'h008, 32'd2, "R4 control bits");

        // R5/R6/R7 two-stage expiry with reset enabled
        wr(12'h008, 32'd3);
        rd(12'h004, LV, "R5 reload on enable");
        wait_irq(k);
        chk(k, 32'd9, "R6 first expiry cycle");
        wait_rst(k);
        chk(k, 32'd10, "R7 second expiry cycle");
        k = 0;
        do begin @(posedge clk); #1; k++; end while (sys_rst_o && k < 100);
        @(negedge clk);
        chk(k, RSTC, "R7 pulse width");
        rd(12'h010, 32'd1, "R9 raw after expiry");
        rd(12'h014, 32'd1, "R9 masked after expiry");

        // R8 service
        wr(12'h00C, 32'hDEAD0000);
        rd(12'h004, LV, "R8 reload on clear");
        rd(12'h010, 32'd0, "R8 raw cleared");

        // R7 reset disabled: no pulse
        wr(12'h008, 32'd1);
        wait_irq(k);
        chk(k, 32'd10, "R6 first expiry, reset off");
        seen = 0;
        for (int i = 0; i < 22; i++) begin
            @(posedge clk); #1;
            if (sys_rst_o) seen = 1;
        end
        @(negedge clk);
        chk(seen, 32'd0, "R7 no pulse when disabled");
        chk({31'd0, irq_o}, 32'd1, "R7 irq held");

        // R9 disable with pending interrupt
        wr(12'h008, 32'd0);
        rd(12'h014, 32'd0, "R9 masked off");
        rd(12'h010, 32'd1, "R9 raw kept");
        chk({31'd0, irq_o}, 32'd0, "R9 irq_o off");

        // R10 hold while disabled
        wr(12'h00C, 32'd0);
        rd(12'h004, LV, "R8 reload while stopped");
        repeat (5) @(negedge clk);
        rd(12'h004, LV, "R10 counter held");

        // R5 counter is read-only
        wr(12'h004, 32'd5);
        rd(12'h004, LV, "R5 count write ignored");

        // R2 relock, R3 again
        wr(12'hC00, 32'd0);
        rd(12'hC00, 32'd1, "R2 relock");
        wr(12'h000, 32'd3);
        rd(12'h000, LV, "R3 load after relock");

        @(negedge clk);
        summary();
        $finish;
    end
endmodule